// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the host side of a parallel bus. On that bus is a bank of clockless, UV-erasable 2048 x 8 read-only memories. A client asks for one byte with a single-cycle request that carries an 11-bit word address and a device number. The controller then runs the whole read cycle. It puts the address on the bus, pulls the chip enable of the chosen device low, and waits. It then pulls the output enable low, which is shared across the bank, and waits again. It latches the byte on the same edge that releases both enables. Finally it returns the byte with a one-cycle acknowledge.

All delays are given in nanoseconds as parameters, together with the clock period. Each delay becomes a cycle count by rounding up the quotient. The output enable is held back from the chip enable by the difference between the full access time and the output-enable access time, so the read never takes longer than the full access time. The chip enable is decoded per device, so the parts that are not selected stay in standby.

After reset, the controller makes one throwaway change on the address lines before it accepts any request. The memories need this address change before their outputs are valid. After every read, the controller also waits out the output-float time before the next device may be enabled.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While `rst` is high: `ce_n_o` is all ones, `oe_n_o` is 1, `ack_o` and `ready_o` are 0, `addr_o` and `data_o` are 0.
- R2: On the first clock edge after reset is released, `addr_o` changes from all zeros to all ones and `ready_o` rises. No chip enable is asserted before this address change.
- R3: A request (`req_i` high at a clock edge) is taken only while `ready_o` is 1. A request made while busy has no effect: the address, device and returned byte of the read in progress are unchanged, and no extra acknowledge follows.
- R4: On the edge that takes a request, `addr_o` takes `addr_i` and only bit `dev_i` of `ce_n_o` goes low (bit k of `ce_n_o` selects device k). `ready_o` falls on the same edge. At most one chip enable is ever low.
- R5: `oe_n_o` falls LEAD edges after the chip enable falls. LEAD = ceil(T_ACC/T_CLK) - ceil(T_OE/T_CLK), which is 17 edges at the defaults (50 MHz, 450 ns, 120 ns).
- R6: ceil(T_ACC/T_CLK) edges after the chip enable falls (23 at the defaults), `data_i` is captured into `data_o` and `ack_o` is high for exactly one cycle. `data_o` changes only on an acknowledge.
- R7: The chip enable and the output enable return high on the same edge that captures the byte.
- R8: `ready_o` rises ceil(T_DF/T_CLK) edges after the output enable rises (5 at the defaults, 100 ns). No chip enable falls within T_DF of an output-enable rise.
- R9: `addr_o` holds steady while a chip enable is low.
- R10: `oe_n_o` is low only while some chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Read request, taken while ready |
| addr_i | input | 11 | Word address of the request |
| dev_i | input | 2 | Device number within the bank |
| ready_o | output | 1 | Idle, a request would be taken |
| ack_o | output | 1 | One-cycle pulse, `data_o` holds the byte read |
| data_o | output | 8 | Last byte read |
| addr_o | output | 11 | Address lines to the bank |
| ce_n_o | output | 4 | Active-low chip enables, one per device |
| oe_n_o | output | 1 | Shared active-low output enable |
| data_i | input | 8 | Data lines from the bank |

## Verification
The bench contains a timing-aware memory model. It drives a byte that depends on both the address and the device only after the enable-low and address-stable times have passed. Before that, and before the first address change after power-up, it drives a garbage value. A read that is too short, or a read that comes before the wake-up address change, therefore returns the wrong byte.

The controller is tried with isolated reads at the corner addresses, with stray requests injected in the middle of a read, and with a request held high for many cycles while the address and device change on every cycle. The last pattern checks that each read latches the address from exactly the edge that took it. Reads to every device confirm the chip-enable decode, and a float-gap monitor checks the spacing between back-to-back reads.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_IDLE,
    ST_LEAD,
    ST_OPEN,
    ST_FLOAT
  } rd_state_e;

  // Round a delay up to whole clock periods, never less than one.
  function automatic int unsigned cyc_of(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/eprom_rd_cedec.sv
module eprom_rd_cedec #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic               en,
  input  logic [DEV_W-1:0]   dev,
  output logic [NUM_DEV-1:0] sel_n
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign sel_n[g] = !(en && (dev == DEV_W'(g)));
  end

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      ack  <= 1'b0;
    end else begin
      ack <= take;
      if (take) dout <= din;
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack |-> $stable(dout)); // R6

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int T_ACC_NS = 450,
  parameter int T_OE_NS  = 120,
  parameter int T_DF_NS  = 100,
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int NUM_DEV  = 4,
  parameter int DEV_W    = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DEV_W-1:0]   dev_i,
  output logic               ready_o,
  output logic               ack_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [NUM_DEV-1:0] ce_n_o,
  output logic               oe_n_o,
  input  logic [DATA_W-1:0]  data_i
);

  localparam int ACC_CYC  = int'(cyc_of(T_ACC_NS, CLK_NS));
  localparam int OE_CYC   = int'(cyc_of(T_OE_NS, CLK_NS));
  localparam int DF_CYC   = int'(cyc_of(T_DF_NS, CLK_NS));
  localparam int LEAD_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int OPEN_CYC = ACC_CYC - LEAD_CYC;
  localparam int CNT_MAX  = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] LEAD_LD  = CNT_W'((LEAD_CYC > 0) ? LEAD_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] OPEN_LD  = CNT_W'(OPEN_CYC - 1);
  localparam logic [CNT_W-1:0] FLOAT_LD = CNT_W'(DF_CYC - 1);

  rd_state_e          st_q, st_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DEV_W-1:0]   dev_q, dev_d;
  logic               ce_en_q, ce_en_d;
  logic               oe_n_q, oe_n_d;
  logic               ready_q, ready_d;
  logic [NUM_DEV-1:0] ce_n_q, ce_n_nxt;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               take;
  logic               ce_any;

  eprom_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  eprom_rd_cedec #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_cedec (
    .en    (ce_en_d),
    .dev   (dev_d),
    .sel_n (ce_n_nxt)
  );

  eprom_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .din  (data_i),
    .dout (data_o),
    .ack  (ack_o)
  );

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    dev_d    = dev_q;
    ce_en_d  = ce_en_q;
    oe_n_d   = oe_n_q;
    ready_d  = ready_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    unique case (st_q)
      ST_WAKE: begin
        // One throwaway address change so the parts leave power-up state.
        addr_d  = '1;
        ready_d = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_i) begin
          addr_d   = addr_i;
          dev_d    = dev_i;
          ce_en_d  = 1'b1;
          ready_d  = 1'b0;
          tmr_load = 1'b1;
          if (LEAD_CYC == 0) begin
            oe_n_d  = 1'b0;
            tmr_val = OPEN_LD;
            st_d    = ST_OPEN;
          end else begin
            tmr_val = LEAD_LD;
            st_d    = ST_LEAD;
          end
        end
      end
      ST_LEAD: begin
        if (tmr_zero) begin
          oe_n_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = OPEN_LD;
          st_d     = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (tmr_zero) begin
          take     = 1'b1;
          ce_en_d  = 1'b0;
          oe_n_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = FLOAT_LD;
          st_d     = ST_FLOAT;
        end
      end
      ST_FLOAT: begin
        if (tmr_zero) begin
          ready_d = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_WAKE;
      addr_q  <= '0;
      dev_q   <= '0;
      ce_en_q <= 1'b0;
      oe_n_q  <= 1'b1;
      ready_q <= 1'b0;
      ce_n_q  <= '1;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      dev_q   <= dev_d;
      ce_en_q <= ce_en_d;
      oe_n_q  <= oe_n_d;
      ready_q <= ready_d;
      ce_n_q  <= ce_n_nxt;
    end
  end

  assign addr_o  = addr_q;
  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign ready_o = ready_q;
  assign ce_any  = (ce_n_q != '1);

  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ce_n_o) <= 1); // R4

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> ce_any); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (ce_any && $past(ce_any)) |-> $stable(addr_o)); // R9

  AST_RELEASE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (oe_n_o && !ce_any)); // R7

  AST_TAKE_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_any) |-> $past(ready_o)); // R3

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
module eprom_rd_ctrl_tb;

  localparam int CLK   = 20;
  localparam int TACC  = 450;
  localparam int TOE   = 120;
  localparam int TDF   = 100;
  localparam int ACC   = (TACC + CLK - 1) / CLK;
  localparam int OEC   = (TOE + CLK - 1) / CLK;
  localparam int DFC   = (TDF + CLK - 1) / CLK;
  localparam int LEAD  = ACC - OEC;
  localparam int OPEN  = OEC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [1:0]  dev_i = '0;
  logic        ready_o, ack_o, oe_n_o;
  logic [7:0]  data_o;
  logic [10:0] addr_o;
  logic [3:0]  ce_n_o;
  logic [7:0]  data_i = 8'hEE;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK/2) clk = ~clk;

  eprom_rd_ctrl u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .dev_i(dev_i),
    .ready_o(ready_o), .ack_o(ack_o), .data_o(data_o), .addr_o(addr_o),
    .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .data_i(data_i)
  );

  function automatic logic [7:0] rom(input int d, input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10101} ^ 8'(d * 59);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, advanced on every rising edge.
  int          m_ph = 0;
  int          m_t = 0;
  int          m_dev = 0;
  logic [10:0] m_addr = '0;
  bit          m_ce = 0, m_oe = 0, m_ack = 0, m_ready = 0;
  logic [7:0]  m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_t = 0; m_dev = 0; m_addr = '0;
      m_ce = 0; m_oe = 0; m_ack = 0; m_ready = 0; m_data = '0;
    end else begin
      m_ack = 0;
      case (m_ph)
        0: begin m_addr = '1; m_ready = 1; m_ph = 1; end
        1: if (req_i) begin
             m_addr = addr_i; m_dev = int'(dev_i); m_ce = 1;
             m_ready = 0; m_t = 0; m_ph = 2;
           end
        2: begin m_t++; if (m_t == LEAD) begin m_oe = 1; m_t = 0; m_ph = 3; end end
        3: begin
             m_t++;
             if (m_t == OPEN) begin
               m_data = rom(m_dev, m_addr); m_ack = 1;
               m_ce = 0; m_oe = 0; m_t = 0; m_ph = 4;
             end
           end
        default: begin m_t++; if (m_t == DFC) begin m_ready = 1; m_ph = 1; end end
      endcase
    end
  end

  // Memory bank model and bus monitors, updated between edges.
  int          acc_cnt = 0, oe_cnt = 0, flt_cnt = 1000;
  bit          woke = 0, any_prev = 0;
  logic [10:0] addr_prev = '0;
  logic [3:0]  ce_prev = 4'hF;

  always @(negedge clk) begin
    int nlow;
    int sel;
    bit any_now;
    nlow = 0; sel = 0;
    for (int k = 0; k < 4; k++) if (!ce_n_o[k]) begin nlow++; sel = k; end
    any_now = (nlow != 0);
    if (!rst) begin
      if (addr_o != addr_prev) woke = 1;
      if (any_now && !any_prev) begin
        chk(woke, "R2 wake change before enable", woke, 1);
        chk((flt_cnt - 1) * CLK >= TDF, "R8 float gap", (flt_cnt - 1) * CLK, TDF);
      end
      if (any_now && any_prev)
        chk(addr_o == addr_prev, "R9 address held", addr_o, addr_prev);
      if (!oe_n_o) chk(any_now, "R10 oe without ce", nlow, 1);
      chk(nlow <= 1, "R4 single enable", nlow, 1);
    end
    if (nlow == 1 && ce_n_o == ce_prev && addr_o == addr_prev) acc_cnt++;
    else acc_cnt = (nlow == 1) ? 1 : 0;
    oe_cnt  = (!oe_n_o && nlow == 1) ? oe_cnt + 1 : 0;
    flt_cnt = oe_n_o ? flt_cnt + 1 : 0;
    data_i = (woke && acc_cnt * CLK >= TACC && oe_cnt * CLK >= TOE) ? rom(sel, addr_o) : 8'hEE;
    addr_prev = addr_o;
    ce_prev   = ce_n_o;
    any_prev  = any_now;
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    logic [3:0] exp_ce;
    exp_ce = m_ce ? ~(4'b0001 << m_dev) : 4'hF;
    if (!done) begin
      chk(addr_o == m_addr, "R4 addr_o", addr_o, m_addr);
      chk(ce_n_o == exp_ce, "R4 ce_n_o", ce_n_o, exp_ce);
      chk(oe_n_o == !m_oe, "R5 oe_n_o", oe_n_o, !m_oe);
      chk(ack_o == m_ack, "R6 ack_o", ack_o, m_ack);
      chk(data_o == m_data, "R6 data_o", data_o, m_data);
      chk(ready_o == m_ready, "R8 ready_o", ready_o, m_ready);
      if (ack_o) chk(oe_n_o && ce_n_o == 4'hF, "R7 release at capture", {oe_n_o, ce_n_o}, 5'h1F);
    end
  end

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  task automatic wait_ack();
    while (!ack_o) @(negedge clk);
  endtask

  task automatic one_read(input logic [10:0] a, input int d, input bit stray);
    wait_ready();
    req_i = 1; addr_i = a; dev_i = 2'(d);
    @(negedge clk);
    req_i = 0;
    if (stray) begin
      repeat (5) @(negedge clk);
      req_i = 1; addr_i = ~a; dev_i = 2'(d + 1);
      @(negedge clk);
      req_i = 0;
      repeat (8) @(negedge clk);
      req_i = 1; addr_i = a ^ 11'h0F0;
      @(negedge clk);
      req_i = 0;
    end
    wait_ack();
    chk(data_o == rom(d, a), "R3 byte of taken request", data_o, rom(d, a));
    @(negedge clk);
    chk(!ack_o, "R3 no extra ack", ack_o, 0);
  endtask

  initial begin
    logic [10:0] lfsr;
    repeat (3) @(negedge clk);
    chk(ce_n_o == 4'hF && oe_n_o && !ack_o && !ready_o, "R1 controls in reset",
        {ce_n_o, oe_n_o, ack_o, ready_o}, 7'h7C);
    chk(addr_o == 0 && data_o == 0, "R1 buses in reset", {addr_o, data_o}, 0);
    rst = 0;
    @(negedge clk);
    chk(addr_o == 11'h7FF && ready_o, "R2 wake change", {ready_o, addr_o}, 12'hFFF);

    one_read(11'h000, 0, 0);
    one_read(11'h7FF, 0, 1);
    one_read(11'h555, 1, 0);
    one_read(11'h2AA, 2, 1);
    for (int d = 0; d < 4; d++) begin
      one_read(11'h7FF, d, 0);
      one_read(11'h001, d, 1);
    end

    // Request held high, address and device changing every cycle.
    lfsr = 11'h3A5;
    wait_ready();
    req_i = 1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[9:0], lfsr[10] ^ lfsr[8]};
      addr_i = lfsr; dev_i = lfsr[4:3];
      @(negedge clk);
    end
    req_i = 0;
    wait_ready();
    repeat (4) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule